// File: doc/BRIEF.md
# Paged Memory Map Address Decoder

This block decodes every address a 16-bit CPU places on its bus into one of five outcomes: the peripheral register block, RAM, EEPROM, flash, or no target at all. The register block, RAM and EEPROM each sit at a base that software can move, and RAM and EEPROM can be switched off. Flash fills the upper three quarters of the 64 KB map. The two outer 16 KB quarters, 0x4000 and 0xC000, are tied to fixed flash pages. The quarter at 0x8000 is a window whose flash page comes from a page register.

When blocks overlap, a fixed priority settles which one answers. A moved block therefore hides whatever lies beneath it, including the flash interrupt vectors at the top of the map. Along with the selects, the decoder gives the 18-bit physical flash address for the 256 KB flash array. The upper four bits of that address are the page index. The lower fourteen bits are the offset within the 16 KB quarter.

Configuration writes arrive through a strobe with a 3-bit offset and take effect on the next clock edge. Decoding is combinational from the address and the registered configuration.

Top module: `mmap_decoder`

## Requirements
- R1: After reset the page register holds 0x00. The register block covers 0x0000–0x03FF, RAM covers 0x1000–0x3FFF, EEPROM covers 0x0000–0x0FFF, and RAM and EEPROM are both enabled.
- R2: For every address exactly one of sel_regs, sel_ram, sel_eep, sel_flash, unmapped is high.
- R3: Overlaps resolve in this order, highest first: register block (1 KB), RAM (12 KB), EEPROM (4 KB), flash. Only the winner is selected, and RAM also beats the paged window.
- R4: Flash addresses 0x4000–0x7FFF map to page 0x3E and 0xC000–0xFFFF map to page 0x3F, whatever the page register holds.
- R5: In the window 0x8000–0xBFFF, a page of 0x30–0x3F gives flash_addr = {page[3:0], cpu_addr[13:0]}.
- R6: A window address with a page outside 0x30–0x3F, or any address 0x0000–0x3FFF outside every enabled block, raises unmapped only.
- R7: Page 0x3E makes the window show the same physical flash as 0x4000–0x7FFF. Page 0x3F makes it show the same physical flash as 0xC000–0xFFFF.
- R8: When cfg_we is high, offset 0 loads the page from cfg_wdata[5:0]. Offsets 1, 2 and 3 load the register-block, RAM and EEPROM base as address bits [15:10] from cfg_wdata[5:0]. Offset 4 loads the RAM enable from bit 0 and the EEPROM enable from bit 1. The new value decodes from the cycle after the write edge.
- R9: A disabled RAM or EEPROM is never selected, and the block below it answers instead.
- R10: RAM moved over 0xFF80–0xFFFF is selected there, and flash is not.
- R11: A block whose base plus size passes 0xFFFF is cut off at 0xFFFF and does not wrap to 0x0000.
- R12: With cfg_we low, or with offsets 5–7, no configuration changes.
- R13: flash_addr is zero whenever sel_flash is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_off | input | 3 | Configuration register offset |
| cfg_wdata | input | 6 | Configuration write data |
| cpu_addr | input | 16 | CPU bus address |
| sel_regs | output | 1 | Register block selected |
| sel_ram | output | 1 | RAM selected |
| sel_eep | output | 1 | EEPROM selected |
| sel_flash | output | 1 | Flash selected |
| unmapped | output | 1 | Address reaches no target |
| flash_addr | output | 18 | Physical flash address |

## Verification
The assertions check on every cycle that exactly one select is high. They check that the fixed quarters always carry pages 0x3E and 0x3F, that window accesses carry the page register's index, and that the offset bits pass through unchanged. They also check that an invalid page never selects flash window memory, that configuration holds without a write, and that an addressed write lands on the next edge. Only the bench's address sweeps under several configurations can show the full picture. Those configurations are the reset layout, valid, aliased and invalid pages, blocks stacked on one another, RAM over the vectors, a base clipped at the top of the map, and disabled blocks. Across them the sweeps show that the priority order and the address ranges are right everywhere.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int ADDR_W     = 16;
    localparam int WIN_W      = 14;
    localparam int PAGE_W     = 6;
    localparam int PAGE_IDX_W = 4;
    localparam int BASE_LSB   = 10;
    localparam int BASE_W     = ADDR_W - BASE_LSB;
    localparam int DATA_W     = 6;
    localparam int OFF_W      = 3;
    localparam int FLASH_AW   = PAGE_IDX_W + WIN_W;
    localparam int NUM_BLK    = 3;

    localparam logic [PAGE_W-1:0] PAGE_FIX_LO = 6'h3E;
    localparam logic [PAGE_W-1:0] PAGE_FIX_HI = 6'h3F;

    localparam logic [OFF_W-1:0] OFF_PAGE = 3'd0;
    localparam logic [OFF_W-1:0] OFF_REGB = 3'd1;
    localparam logic [OFF_W-1:0] OFF_RAMB = 3'd2;
    localparam logic [OFF_W-1:0] OFF_EEPB = 3'd3;
    localparam logic [OFF_W-1:0] OFF_ENAB = 3'd4;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_REGS,
        HIT_RAM,
        HIT_EEP,
        HIT_FLASH
    } hit_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [BASE_W-1:0] reg_base;
        logic [BASE_W-1:0] ram_base;
        logic [BASE_W-1:0] eep_base;
        logic              ram_en;
        logic              eep_en;
    } map_cfg_t;

endpackage

// File: rtl/mmap_cfg_regs.sv
module mmap_cfg_regs
    import mmap_pkg::*;
#(
    parameter logic [BASE_W-1:0] REG_BASE_RST = 6'h00,
    parameter logic [BASE_W-1:0] RAM_BASE_RST = 6'h04,
    parameter logic [BASE_W-1:0] EEP_BASE_RST = 6'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [DATA_W-1:0] cfg_wdata,
    output map_cfg_t          cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.page     <= '0;
            cfg.reg_base <= REG_BASE_RST;
            cfg.ram_base <= RAM_BASE_RST;
            cfg.eep_base <= EEP_BASE_RST;
            cfg.ram_en   <= 1'b1;
            cfg.eep_en   <= 1'b1;
        end else if (cfg_we) begin
            case (cfg_off)
                OFF_PAGE: cfg.page     <= cfg_wdata[PAGE_W-1:0];
                OFF_REGB: cfg.reg_base <= cfg_wdata[BASE_W-1:0];
                OFF_RAMB: cfg.ram_base <= cfg_wdata[BASE_W-1:0];
                OFF_EEPB: cfg.eep_base <= cfg_wdata[BASE_W-1:0];
                OFF_ENAB: begin
                    cfg.ram_en <= cfg_wdata[0];
                    cfg.eep_en <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    // R12: no strobe, no change
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg));

    // R8: page write lands on the next edge
    p_page_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_off == OFF_PAGE) |=> cfg.page == $past(cfg_wdata[PAGE_W-1:0]));

    // R8: RAM base write lands on the next edge
    p_ramb_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_off == OFF_RAMB) |=> cfg.ram_base == $past(cfg_wdata[BASE_W-1:0]));

endmodule

// File: rtl/mmap_window_match.sv
module mmap_window_match
    import mmap_pkg::*;
#(
    parameter int SIZE = 1024
) (
    input  logic [BASE_W-1:0] base,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W:0] SIZE_EXT = (ADDR_W+1)'(SIZE);

    logic [ADDR_W-1:0] lo;
    logic [ADDR_W:0]   hi;

    always_comb begin
        lo  = {base, {BASE_LSB{1'b0}}};
        hi  = {1'b0, lo} + SIZE_EXT;
        hit = en && (addr >= lo) && ({1'b0, addr} < hi);
    end

endmodule

// File: rtl/mmap_flash_xlate.sv
module mmap_flash_xlate
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PAGE_W-1:0]   page,
    output logic                ok,
    output logic [FLASH_AW-1:0] phys
);

    localparam int Q_W = ADDR_W - WIN_W;

    logic [PAGE_W-1:0] eff_page;
    logic              page_ok;

    always_comb begin
        page_ok  = &page[PAGE_W-1:PAGE_IDX_W];
        eff_page = '0;
        ok       = 1'b0;
        unique case (addr[ADDR_W-1 -: Q_W])
            2'b00: begin
                eff_page = '0;
                ok       = 1'b0;
            end
            2'b01: begin
                eff_page = PAGE_FIX_LO;
                ok       = 1'b1;
            end
            2'b10: begin
                eff_page = page;
                ok       = page_ok;
            end
            2'b11: begin
                eff_page = PAGE_FIX_HI;
                ok       = 1'b1;
            end
        endcase
        phys = {eff_page[PAGE_IDX_W-1:0], addr[WIN_W-1:0]};
    end

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int REG_SIZE = 1024,
    parameter int RAM_SIZE = 12288,
    parameter int EEP_SIZE = 4096,
    parameter logic [BASE_W-1:0] REG_BASE_RST = 6'h00,
    parameter logic [BASE_W-1:0] RAM_BASE_RST = 6'h04,
    parameter logic [BASE_W-1:0] EEP_BASE_RST = 6'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_off,
    input  logic [5:0]          cfg_wdata,
    input  logic [15:0]         cpu_addr,
    output logic                sel_regs,
    output logic                sel_ram,
    output logic                sel_eep,
    output logic                sel_flash,
    output logic                unmapped,
    output logic [17:0]         flash_addr
);

    map_cfg_t          cfg;
    logic [BASE_W-1:0] blk_base [NUM_BLK];
    logic              blk_en   [NUM_BLK];
    logic [NUM_BLK-1:0] blk_hit;
    logic              fl_ok;
    logic [FLASH_AW-1:0] fl_phys;
    hit_e              winner;

    mmap_cfg_regs #(
        .REG_BASE_RST (REG_BASE_RST),
        .RAM_BASE_RST (RAM_BASE_RST),
        .EEP_BASE_RST (EEP_BASE_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_off   (cfg_off),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    always_comb begin
        blk_base[0] = cfg.reg_base;
        blk_base[1] = cfg.ram_base;
        blk_base[2] = cfg.eep_base;
        blk_en[0]   = 1'b1;
        blk_en[1]   = cfg.ram_en;
        blk_en[2]   = cfg.eep_en;
    end

    // index 0 = register block, 1 = RAM, 2 = EEPROM (also priority order)
    for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_blk
        localparam int SZ = (gi == 0) ? REG_SIZE : (gi == 1) ? RAM_SIZE : EEP_SIZE;
        mmap_window_match #(.SIZE(SZ)) u_match (
            .base (blk_base[gi]),
            .en   (blk_en[gi]),
            .addr (cpu_addr),
            .hit  (blk_hit[gi])
        );
    end

    mmap_flash_xlate u_xlate (
        .addr (cpu_addr),
        .page (cfg.page),
        .ok   (fl_ok),
        .phys (fl_phys)
    );

    always_comb begin
        if (blk_hit[0])      winner = HIT_REGS;
        else if (blk_hit[1]) winner = HIT_RAM;
        else if (blk_hit[2]) winner = HIT_EEP;
        else if (fl_ok)      winner = HIT_FLASH;
        else                 winner = HIT_NONE;
    end

    always_comb begin
        sel_regs   = 1'b0;
        sel_ram    = 1'b0;
        sel_eep    = 1'b0;
        sel_flash  = 1'b0;
        unmapped   = 1'b0;
        flash_addr = '0;
        unique case (winner)
            HIT_REGS:  sel_regs = 1'b1;
            HIT_RAM:   sel_ram  = 1'b1;
            HIT_EEP:   sel_eep  = 1'b1;
            HIT_FLASH: begin
                sel_flash  = 1'b1;
                flash_addr = fl_phys;
            end
            default:   unmapped = 1'b1;
        endcase
    end

    // R2: one target per address
    p_one_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_regs, sel_ram, sel_eep, sel_flash, unmapped}) == 1);

    // R4: fixed high quarter uses page 0x3F
    p_fix_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flash && cpu_addr[15:14] == 2'b11) |-> flash_addr[17:14] == PAGE_FIX_HI[3:0]);

    // R4: fixed low quarter uses page 0x3E
    p_fix_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flash && cpu_addr[15:14] == 2'b01) |-> flash_addr[17:14] == PAGE_FIX_LO[3:0]);

    // R5: window carries the page register index, offset passes through
    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flash && cpu_addr[15:14] == 2'b10)
            |-> (flash_addr[17:14] == cfg.page[3:0]) && (flash_addr[13:0] == cpu_addr[13:0]));

    // R6: invalid page never selects flash in the window
    p_bad_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b10 && cfg.page[5:4] != 2'b11) |-> !sel_flash);

    // R13: flash address quiet when flash not selected
    p_fa_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_flash |-> flash_addr == '0);

endmodule

// File: tb/tb_mmap_decoder.sv
module tb_mmap_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_off = '0;
    logic [5:0]  cfg_wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic        sel_regs, sel_ram, sel_eep, sel_flash, unmapped;
    logic [17:0] flash_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    int m_page, m_regb, m_ramb, m_eepb;
    bit m_ram_en, m_eep_en;

    always #2 clk = ~clk;

    mmap_decoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_off    (cfg_off),
        .cfg_wdata  (cfg_wdata),
        .cpu_addr   (cpu_addr),
        .sel_regs   (sel_regs),
        .sel_ram    (sel_ram),
        .sel_eep    (sel_eep),
        .sel_flash  (sel_flash),
        .unmapped   (unmapped),
        .flash_addr (flash_addr)
    );

    task automatic model_reset();
        m_page = 0; m_regb = 'h0000; m_ramb = 'h1000; m_eepb = 'h0000;
        m_ram_en = 1; m_eep_en = 1;
    endtask

    // sel bits: {regs, ram, eep, flash, unmapped}
    function automatic void expect_at(input int a, output logic [4:0] s, output int fa);
        int pg;
        fa = 0;
        if (a >= m_regb && a < m_regb + 1024) s = 5'b10000;
        else if (m_ram_en && a >= m_ramb && a < m_ramb + 12288) s = 5'b01000;
        else if (m_eep_en && a >= m_eepb && a < m_eepb + 4096) s = 5'b00100;
        else begin
            if (a < 'h4000) pg = -1;
            else if (a < 'h8000) pg = 'h3E;
            else if (a < 'hC000) pg = m_page;
            else pg = 'h3F;
            if (pg >= 'h30 && pg <= 'h3F) begin
                s  = 5'b00010;
                fa = ((pg & 15) << 14) | (a & 'h3FFF);
            end else s = 5'b00001;
        end
    endfunction

    task automatic check_now(input string req);
        logic [4:0] es, gs;
        int ef;
        expect_at(int'(cpu_addr), es, ef);
        gs = {sel_regs, sel_ram, sel_eep, sel_flash, unmapped};
        checks++;
        if (gs !== es || int'(flash_addr) != ef) begin
            fails++;
            $display("FAIL %s addr=%h sel=%b fa=%h expected sel=%b fa=%h",
                     req, cpu_addr, gs, flash_addr, es, ef[17:0]);
        end
        checks++;
        if ($countones(gs) != 1) begin
            fails++;
            $display("FAIL R2 addr=%h sel=%b expected one-hot", cpu_addr, gs);
        end
    endtask

    task automatic probe(input int a, input string req);
        @(negedge clk);
        cpu_addr = a[15:0];
        #1;
        check_now(req);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 65536; a += 16) begin
            probe(a, req);
            probe(a + 15, req);
        end
    endtask

    task automatic cfg_write(input int off, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_off = off[2:0]; cfg_wdata = data[5:0];
        @(negedge clk);
        cfg_we = 1'b0;
        case (off)
            0: m_page = data & 'h3F;
            1: m_regb = (data & 'h3F) << 10;
            2: m_ramb = (data & 'h3F) << 10;
            3: m_eepb = (data & 'h3F) << 10;
            4: begin m_ram_en = data[0]; m_eep_en = data[1]; end
            default: ;
        endcase
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset layout, R6 window with page 0x00 unmapped
        sweep("R1");

        // R5 valid window page
        cfg_write(0, 'h35);
        sweep("R5");

        // R7 aliases
        cfg_write(0, 'h3E);
        probe('h9234, "R7");
        probe('h5234, "R7");
        sweep("R7");
        cfg_write(0, 'h3F);
        probe('hA00F, "R7");
        probe('hE00F, "R7");

        // R8 write visible right after the edge; R3 stacked blocks; R10 vectors
        cfg_write(2, 'h34);          // RAM to 0xD000
        cpu_addr = 16'hD000; #1; check_now("R8");
        cfg_write(3, 'h20);          // EEPROM to 0x8000
        cfg_write(1, 'h21);          // registers to 0x8400
        cfg_write(0, 'h31);
        probe('hFF80, "R10");
        probe('hFFFF, "R10");
        sweep("R3");

        // R11 clipping at the top of the map
        cfg_write(2, 'h3C);          // RAM 0xF000 + 12 KB passes 0xFFFF
        probe('hFFFF, "R11");
        probe('h0000, "R11");
        probe('h1000, "R11");
        probe('h0400, "R11");

        // R12 ignored writes
        @(negedge clk);
        cfg_off = 3'd0; cfg_wdata = 6'h2F; cfg_we = 1'b0;
        @(negedge clk);
        cfg_write(5, 'h3F);
        cfg_write(6, 'h00);
        cfg_write(7, 'h00);
        probe('h8000, "R12");
        probe('hF000, "R12");
        probe('h8400, "R12");

        // R9 disabled blocks, R6 invalid page
        cfg_write(2, 'h04);
        cfg_write(3, 'h00);
        cfg_write(1, 'h00);
        cfg_write(4, 'h00);
        cfg_write(0, 'h2F);
        probe('h1000, "R9");
        probe('h0400, "R9");
        sweep("R9");
        probe('h8000, "R6");
        probe('h0800, "R6");

        // R13 flash address zero off flash
        probe('h0000, "R13");

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule